// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This unit sits beside a processor pipeline and decides, every clock cycle, which pending event the core must service. Six request inputs feed it: an exception raised by the instruction that has just completed, a non-maskable external interrupt, a maskable external interrupt, and fault flags from the fetch, decode and execute stages. The unit picks one winner by a fixed ordering. It then uses that event's type number to address an internal table of 256 handler addresses, each 32 bits wide.

One cycle after the winning requests are sampled, the unit raises a single-cycle take pulse. In the same cycle it drives the handler address and the event's type number. Accepting an event clears the global interrupt-enable flag, so maskable requests are held off until software re-enables them. The handler table and the enable flag are loaded through simple write ports. Saving the processor's state is left to the surrounding core.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `take_o` and `ie_o` are 0. No non-maskable request is pending, so no event is taken while every request input is low.
- R2: Events are ranked from highest to lowest as follows: previous-instruction exception, external interrupt, fetch fault, decode fault, execute fault. Only the highest ranked eligible event is accepted in a cycle.
- R3: Within the external class, a pending non-maskable request wins over a maskable request.
- R4: The maskable request `ext_irq` is level-sensitive. It is ignored, producing no take, for as long as `ie_o` is 0.
- R5: A rising edge on `nmi_in` becomes pending at the next clock edge. It stays pending until it is accepted, and it yields exactly one take however long `nmi_in` stays high.
- R6: When requests sampled at a clock edge produce a winner, `take_o` is 1 for one cycle after that edge. In that cycle `type_o` holds the winner's type number and `vec_o` holds the table entry at that index. A previous-instruction exception uses `exc_type`, and a maskable interrupt uses `ext_type`.
- R7: Accepting any event clears `ie_o`. This clear takes precedence over an `ie_we` write issued in the same cycle. Otherwise `ie_we` loads `ie_wd` into `ie_o`.
- R8: If a table write and a lookup hit the same entry in the same cycle, the lookup returns the entry's previous contents. The new contents are returned from the next cycle onward.
- R9: The fixed type numbers are: non-maskable interrupt 2, fetch fault 14, decode fault 6, execute fault 13.
- R10: In a cycle with no eligible request, `take_o` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception raised by the previous instruction |
| exc_type | input | 8 | Type number of that exception |
| ext_irq | input | 1 | Maskable external interrupt, level |
| ext_type | input | 8 | Type number of the maskable interrupt |
| nmi_in | input | 1 | Non-maskable external interrupt, edge |
| fetch_flt | input | 1 | Fault from the fetch stage |
| dec_flt | input | 1 | Fault from the decode stage |
| exe_flt | input | 1 | Fault from the execute stage |
| ie_we | input | 1 | Write strobe for the enable flag |
| ie_wd | input | 1 | New value of the enable flag |
| tbl_we | input | 1 | Handler table write strobe |
| tbl_addr | input | 8 | Handler table write index |
| tbl_data | input | 32 | Handler address to store |
| ie_o | output | 1 | Interrupt-enable flag |
| take_o | output | 1 | One-cycle pulse: event accepted |
| type_o | output | 8 | Type number of the accepted event |
| vec_o | output | 32 | Handler address of the accepted event |

## Verification
The hardest case to reach is a non-maskable request that has become pending but must wait. This happens when a higher-ranked exception or a maskable interrupt competes in the cycle after the edge. The stimulus raises `nmi_in` and then asserts the competitor exactly one cycle later. The scoreboard then expects two takes on consecutive cycles, or the NMI alone with the maskable request shut out because the enable flag was cleared. A second hard case is a table write to the same entry in the very cycle of a lookup. The bench drives a write and an exception of the same type together and expects the old handler first and the new one afterwards.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  // Arbitration slots, index 0 is the highest rank.
  localparam int SLOT_EXC   = 0;
  localparam int SLOT_NMI   = 1;
  localparam int SLOT_EXT   = 2;
  localparam int SLOT_FETCH = 3;
  localparam int SLOT_DEC   = 4;
  localparam int SLOT_EXE   = 5;
  localparam int NUM_SLOTS  = 6;
endpackage

// File: rtl/ivu_nmi_latch.sv
module ivu_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic ack,
  output logic pend
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      pend  <= rise | (pend & ~ack);
    end
  end
endmodule

// File: rtl/ivu_arbiter.sv
module ivu_arbiter
  import ivu_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] NMI_TYPE   = 2,
  parameter logic [TYPE_W-1:0] FETCH_TYPE = 14,
  parameter logic [TYPE_W-1:0] DEC_TYPE   = 6,
  parameter logic [TYPE_W-1:0] EXE_TYPE   = 13
) (
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              nmi_pend,
  input  logic              ext_ok,
  input  logic [TYPE_W-1:0] ext_type,
  input  logic              fetch_flt,
  input  logic              dec_flt,
  input  logic              exe_flt,
  output logic              grant,
  output logic [NUM_SLOTS-1:0] gnt,
  output logic [TYPE_W-1:0] win_type
);
  logic [NUM_SLOTS-1:0] req;
  logic [TYPE_W-1:0]    typ [NUM_SLOTS];

  always_comb begin
    req[SLOT_EXC]   = exc_req;
    req[SLOT_NMI]   = nmi_pend;
    req[SLOT_EXT]   = ext_ok;
    req[SLOT_FETCH] = fetch_flt;
    req[SLOT_DEC]   = dec_flt;
    req[SLOT_EXE]   = exe_flt;
    typ[SLOT_EXC]   = exc_type;
    typ[SLOT_NMI]   = NMI_TYPE;
    typ[SLOT_EXT]   = ext_type;
    typ[SLOT_FETCH] = FETCH_TYPE;
    typ[SLOT_DEC]   = DEC_TYPE;
    typ[SLOT_EXE]   = EXE_TYPE;
  end

  // Scan from lowest rank upward so the highest ranked request overrides.
  always_comb begin
    grant    = 1'b0;
    gnt      = '0;
    win_type = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = 1'b1;
        gnt      = '0;
        gnt[i]   = 1'b1;
        win_type = typ[i];
      end
    end
  end
endmodule

// File: rtl/ivu_vec_table.sv
module ivu_vec_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-clock RAM: a colliding read sees the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int VEC_W  = 32,
  parameter logic [TYPE_W-1:0] NMI_TYPE   = 2,
  parameter logic [TYPE_W-1:0] FETCH_TYPE = 14,
  parameter logic [TYPE_W-1:0] DEC_TYPE   = 6,
  parameter logic [TYPE_W-1:0] EXE_TYPE   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              ext_irq,
  input  logic [TYPE_W-1:0] ext_type,
  input  logic              nmi_in,
  input  logic              fetch_flt,
  input  logic              dec_flt,
  input  logic              exe_flt,
  input  logic              ie_we,
  input  logic              ie_wd,
  input  logic              tbl_we,
  input  logic [TYPE_W-1:0] tbl_addr,
  input  logic [VEC_W-1:0]  tbl_data,
  output logic              ie_o,
  output logic              take_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic                 nmi_pend;
  logic                 ext_ok;
  logic                 grant;
  logic [NUM_SLOTS-1:0] gnt;
  logic [TYPE_W-1:0]    win_type;

  assign ext_ok = ext_irq & ie_o;

  ivu_nmi_latch nmi_i (
    .clk    (clk),
    .rst    (rst),
    .nmi_in (nmi_in),
    .ack    (gnt[SLOT_NMI]),
    .pend   (nmi_pend)
  );

  ivu_arbiter #(
    .TYPE_W     (TYPE_W),
    .NMI_TYPE   (NMI_TYPE),
    .FETCH_TYPE (FETCH_TYPE),
    .DEC_TYPE   (DEC_TYPE),
    .EXE_TYPE   (EXE_TYPE)
  ) arb_i (
    .exc_req   (exc_req),
    .exc_type  (exc_type),
    .nmi_pend  (nmi_pend),
    .ext_ok    (ext_ok),
    .ext_type  (ext_type),
    .fetch_flt (fetch_flt),
    .dec_flt   (dec_flt),
    .exe_flt   (exe_flt),
    .grant     (grant),
    .gnt       (gnt),
    .win_type  (win_type)
  );

  ivu_vec_table #(
    .ADDR_W (TYPE_W),
    .DATA_W (VEC_W)
  ) tbl_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .re    (grant),
    .raddr (win_type),
    .rdata (vec_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o   <= 1'b0;
      take_o <= 1'b0;
      type_o <= '0;
    end else begin
      take_o <= grant;
      if (grant) begin
        type_o <= win_type;
        ie_o   <= 1'b0;
      end else if (ie_we) begin
        ie_o   <= ie_wd;
      end
    end
  end
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker #(
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] NMI_TYPE   = 2,
  parameter logic [TYPE_W-1:0] FETCH_TYPE = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_req,
  input logic [TYPE_W-1:0] exc_type,
  input logic              ext_irq,
  input logic              nmi_pend,
  input logic              fetch_flt,
  input logic              dec_flt,
  input logic              exe_flt,
  input logic              ie_o,
  input logic              take_o,
  input logic [TYPE_W-1:0] type_o
);
  // R2 / R6: an exception always wins and reports its own number.
  p_exc_wins_r2: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (take_o && type_o == $past(exc_type)));

  // R5 / R3: a pending NMI is taken next unless an exception outranks it.
  p_nmi_served_r5: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !exc_req) |=> (take_o && type_o == NMI_TYPE));

  // R4: with the flag clear, a lone maskable request yields nothing.
  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (!ie_o && !exc_req && !nmi_pend && !fetch_flt && !dec_flt && !exe_flt)
      |=> !take_o);

  // R10: nothing eligible means no take.
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !nmi_pend && !(ext_irq && ie_o) && !fetch_flt && !dec_flt && !exe_flt)
      |=> !take_o);

  // R7: every take comes with the flag cleared.
  p_take_clears_ie_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ie_o);

  // R9: a fetch fault that wins carries its fixed number.
  p_fetch_type_r9: assert property (@(posedge clk) disable iff (rst)
    (fetch_flt && !exc_req && !nmi_pend && !(ext_irq && ie_o))
      |=> (take_o && type_o == FETCH_TYPE));
endmodule

bind irq_vector_unit ivu_checker #(
  .TYPE_W     (TYPE_W),
  .NMI_TYPE   (NMI_TYPE),
  .FETCH_TYPE (FETCH_TYPE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .exc_req   (exc_req),
  .exc_type  (exc_type),
  .ext_irq   (ext_irq),
  .nmi_pend  (nmi_pend),
  .fetch_flt (fetch_flt),
  .dec_flt   (dec_flt),
  .exe_flt   (exe_flt),
  .ie_o      (ie_o),
  .take_o    (take_o),
  .type_o    (type_o)
);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req, ext_irq, nmi_in, fetch_flt, dec_flt, exe_flt;
  logic [7:0]  exc_type, ext_type, tbl_addr;
  logic        ie_we, ie_wd, tbl_we;
  logic [31:0] tbl_data;
  logic        ie_o, take_o;
  logic [7:0]  type_o;
  logic [31:0] vec_o;

  always #4 clk = ~clk; // 125 MHz

  irq_vector_unit dut_i (
    .clk(clk), .rst(rst),
    .exc_req(exc_req), .exc_type(exc_type),
    .ext_irq(ext_irq), .ext_type(ext_type),
    .nmi_in(nmi_in),
    .fetch_flt(fetch_flt), .dec_flt(dec_flt), .exe_flt(exe_flt),
    .ie_we(ie_we), .ie_wd(ie_wd),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .ie_o(ie_o), .take_o(take_o), .type_o(type_o), .vec_o(vec_o)
  );

  typedef struct {
    int          due;
    logic [7:0]  typ;
    logic [31:0] vec;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model [256];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          mon_on = 1'b0;

  function automatic logic [31:0] hval(input logic [7:0] t);
    return {8'hC0, t, ~t, t ^ 8'h5A};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: outputs settle after posedge, sampled at negedge.
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (take_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected take type", {24'h0, type_o}, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.due, e.req, "take cycle", cyc, e.due);
          check(type_o == e.typ, e.req, "type", {24'h0, type_o}, {24'h0, e.typ});
          check(vec_o == e.vec, e.req, "vector", vec_o, e.vec);
        end
      end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
        check(1'b0, sb_q[0].req, "missing take at cycle", cyc, sb_q[0].due);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_take(input int delay, input logic [7:0] t, input string req);
    exp_t e;
    e.due = cyc + delay;
    e.typ = t;
    e.vec = model[t];
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic clear_in();
    exc_req = 0; ext_irq = 0; nmi_in = 0;
    fetch_flt = 0; dec_flt = 0; exe_flt = 0;
    ie_we = 0; ie_wd = 0; tbl_we = 0;
  endtask

  task automatic set_ie(input bit v);
    ie_we = 1; ie_wd = v;
    tick();
    ie_we = 0;
  endtask

  task automatic drain();
    repeat (3) tick();
    check(sb_q.size() == 0, "R6", "scoreboard left", sb_q.size(), 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    exc_type = 0; ext_type = 0; tbl_addr = 0; tbl_data = 0;
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check(take_o == 0, "R1", "take after reset", take_o, 0);
    check(ie_o == 0, "R1", "ie after reset", ie_o, 0);
    mon_on = 1'b1;

    // Load the handler table.
    for (int t = 0; t < 256; t++) begin
      tbl_we = 1; tbl_addr = t[7:0]; tbl_data = hval(t[7:0]);
      model[t] = hval(t[7:0]);
      tick();
    end
    tbl_we = 0;
    repeat (2) tick();

    // R1 / R10: idle, monitor flags any spurious take
    repeat (4) tick();
    check(take_o == 0, "R10", "idle take", take_o, 0);

    // R6: lone exception, one cycle latency
    exc_req = 1; exc_type = 8'h20;
    expect_take(1, 8'h20, "R6");
    tick();
    exc_req = 0;
    drain();

    // R2: everything at once, exception wins
    set_ie(1);
    exc_req = 1; exc_type = 8'h33; ext_irq = 1; ext_type = 8'h41;
    fetch_flt = 1; dec_flt = 1; exe_flt = 1;
    expect_take(1, 8'h33, "R2");
    tick();
    clear_in();
    tick();
    // R7: acceptance cleared the flag
    check(ie_o == 0, "R7", "ie after accept", ie_o, 0);
    drain();

    // R2: external beats stage faults
    set_ie(1);
    ext_irq = 1; ext_type = 8'h41; fetch_flt = 1; dec_flt = 1; exe_flt = 1;
    expect_take(1, 8'h41, "R2");
    tick();
    clear_in();
    drain();

    // R9 / R2: fault classes and their fixed numbers
    fetch_flt = 1; dec_flt = 1; exe_flt = 1;
    expect_take(1, 8'd14, "R9");
    tick();
    fetch_flt = 0;
    expect_take(1, 8'd6, "R9");
    tick();
    dec_flt = 0;
    expect_take(1, 8'd13, "R9");
    tick();
    clear_in();
    drain();

    // R4: maskable held while disabled, then enabled (level)
    ext_irq = 1; ext_type = 8'h55;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(take_o == 0, "R4", "masked take", take_o, 0);
    end
    ie_we = 1; ie_wd = 1;
    expect_take(2, 8'h55, "R4");
    tick();
    ie_we = 0;
    tick();
    tick();
    ext_irq = 0;
    drain();

    // R5: NMI held high gives exactly one take, regardless of flag
    nmi_in = 1;
    expect_take(2, 8'd2, "R5");
    repeat (6) tick();
    nmi_in = 0;
    drain();

    // R3: pending NMI beats maskable; flag cleared blocks the maskable
    set_ie(1);
    nmi_in = 1;
    expect_take(2, 8'd2, "R3");
    tick();
    ext_irq = 1; ext_type = 8'h66;
    repeat (3) tick();
    check(take_o == 0, "R3", "maskable after NMI", take_o, 0);
    clear_in();
    drain();

    // R5: NMI stays pending behind an exception
    nmi_in = 1;
    tick();
    exc_req = 1; exc_type = 8'h77;
    expect_take(1, 8'h77, "R5");
    expect_take(2, 8'd2, "R5");
    tick();
    exc_req = 0;
    tick();
    nmi_in = 0;
    drain();

    // R7: accept beats a same-cycle flag write; plain write then sets it
    fetch_flt = 1; ie_we = 1; ie_wd = 1;
    expect_take(1, 8'd14, "R7");
    tick();
    clear_in();
    check(ie_o == 0, "R7", "ie after collide", ie_o, 0);
    set_ie(1);
    check(ie_o == 1, "R7", "ie after write", ie_o, 1);
    set_ie(0);
    check(ie_o == 0, "R7", "ie after clear", ie_o, 0);

    // R8: same-entry write during lookup returns old word
    exc_req = 1; exc_type = 8'h90;
    tbl_we = 1; tbl_addr = 8'h90; tbl_data = 32'hDEAD_BEEF;
    expect_take(1, 8'h90, "R8");
    tick();
    model[8'h90] = 32'hDEAD_BEEF;
    tbl_we = 0;
    expect_take(1, 8'h90, "R8");
    tick();
    exc_req = 0;
    drain();

    // R10: idle again
    repeat (5) tick();
    check(take_o == 0, "R10", "final idle", take_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule